// File: doc/BRIEF.md
# Staged Serial-to-Parallel Capture Front End

This block takes one serial data line, clocked by the bit clock that travels with the data, and turns it into parallel words. The bit clock runs at the data bit rate and is modelled as the single clock input `clk`. Each incoming bit first passes through a programmable delay stage made of bit-clock register taps. The delay stage is always in the path. A setting of zero passes the bit straight through with no added latency.

The delayed bit stream feeds a chain of halving deserializer stages. With the default 8-bit word there are three of them: 1:2, 2:4 and 4:8. Each stage gathers two consecutive groups from the stage before it and emits one group of twice the width. The last stage's output is the word that a downstream FIFO stores.

The block also exports a free-running write-clock enable at the word rate, which fabric logic can use as its word-rate timing. Alongside it goes a word-valid strobe that marks real words only.

Top module: `stgd_deser`

## Requirements
- R1: When the effective delay setting is 0, the bit sampled by the deserializer on a bit-clock edge is the value of `ser_in` at that same edge (no added latency).
- R2: When the effective delay setting is N (1 to 15), the bit sampled on an edge is the `ser_in` value sampled N edges earlier, or 0 if that edge came before the end of reset.
- R3: The effective delay setting starts at 0 after reset. It is reloaded only from the `dly_sel` value sampled on the last edge of each word (edge index 8k-1 after reset). Changes to `dly_sel` on any other edge have no effect.
- R4: Word k after reset is made of the bits sampled on edges 8k to 8k+7. The bit sampled on edge 8k lands in `word_out[0]` and the bit sampled on edge 8k+7 lands in `word_out[7]`.
- R5: `word_vld` is high for exactly one cycle after edge 8k+9, for each k >= 0, and is low at every other time. In that cycle `word_out` holds word k.
- R6: `wr_ce` is high for one cycle after every edge whose index is 1 modulo 8, counted from the first edge after reset. This includes the first word period, before any word is valid.
- R7: A synchronous active-high `rst` clears the delay taps, the stage registers, the phase counter, `word_out`, `word_vld` and `wr_ce`.
- R8: `word_out` keeps its value in every cycle in which `word_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded bit clock; one edge per data bit |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data line |
| dly_sel | input | DLY_W (4) | Requested delay in bit-clock taps, 0 to 15 |
| word_out | output | WORD_W (8) | Deserialized word, first received bit in bit 0 |
| word_vld | output | 1 | One-cycle strobe marking a new word |
| wr_ce | output | 1 | Free-running word-rate write enable for the downstream FIFO |

## Verification
The bench sweeps all sixteen delay settings, each held for four words, under three stimulus patterns. A pseudo-random bit stream catches wrong tap selection and lost or repeated bits. A walking single one with a period of nine moves through every bit position and so shows bit-order or stage-swap faults that random data could hide. A third pass puts noise on `dly_sel` everywhere except the word's last edge, which shows whether the setting is taken only at the word boundary. The settings change from one segment to the next, so the words that straddle a change check that bits are duplicated or dropped exactly as the boundary reload predicts.

// File: rtl/stgd_deser_pkg.sv
package stgd_deser_pkg;

   // True when v is a power of two of at least 2.
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // Cycle phase at which the final halving stage emits its word:
   // stage s emits at phase (s - 1) mod WORD_W, s counted from 0.
   function automatic int emit_phase(input int word_w, input int nstg);
      return (nstg + word_w - 2) % word_w;
   endfunction

endpackage

// File: rtl/stgd_phase_ctr.sv
module stgd_phase_ctr #(
   parameter int CNT_W   = 3,
   parameter int CE_PH   = 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] phase,
   output logic             last,
   output logic             wr_ce
);
   localparam logic [CNT_W-1:0] LAST_PH = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CE_VAL  = CNT_W'(CE_PH);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("stgd_phase_ctr: CNT_W must be at least 1");
      end
      if (CE_PH < 0 || CE_PH >= (1 << CNT_W)) begin : g_bad_ph
         $error("stgd_phase_ctr: CE_PH out of range");
      end
   endgenerate

   assign last = (phase == LAST_PH);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         wr_ce <= 1'b0;
      end else begin
         phase <= phase + 1'b1;
         wr_ce <= (phase == CE_VAL);
      end
   end

   // R6: the counter wraps after its last phase
   p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      last |=> (phase == '0));

   // R6: otherwise it steps by one
   p_step_r6: assert property (@(posedge clk) disable iff (rst)
      !last |=> (phase == $past(phase) + 1'b1));

   // R6: the write enable is a single-cycle pulse
   p_ce_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      wr_ce |=> !wr_ce);

endmodule

// File: rtl/stgd_tap_delay.sv
module stgd_tap_delay #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             din,
   input  logic [DLY_W-1:0] dly_sel,
   input  logic             load,
   output logic             dout
);
   localparam int NTAP = (1 << DLY_W) - 1;

   logic [DLY_W-1:0] eff;
   logic [NTAP-1:0]  taps;

   generate
      if (DLY_W < 1 || DLY_W > 8) begin : g_bad_w
         $error("stgd_tap_delay: DLY_W must be 1 to 8");
      end

      if (NTAP == 1) begin : g_one_tap
         always_ff @(posedge clk) begin
            if (rst) taps <= '0;
            else     taps <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) taps <= '0;
            else     taps <= {taps[NTAP-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       eff <= '0;
      else if (load) eff <= dly_sel;
   end

   always_comb begin
      if (eff == '0) dout = din;
      else           dout = taps[eff - 1'b1];
   end

   // R3: the setting only moves on a word boundary
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !$past(load) |-> $stable(eff));

   // R2: one tap of delay gives the previous edge's input
   p_tap1_r2: assert property (@(posedge clk) disable iff (rst)
      (eff == DLY_W'(1)) |-> (dout == $past(din)));

endmodule

// File: rtl/stgd_halve_stage.sv
module stgd_halve_stage #(
   parameter int IN_W  = 1,
   parameter int IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [IN_W-1:0]      in_data,
   input  logic                 in_v,
   input  logic [IDX_W-1:0]     in_idx,
   output logic [2*IN_W-1:0]    out_data,
   output logic                 out_v,
   output logic [IDX_W-1:0]     out_idx
);
   logic [IN_W-1:0] hold;

   generate
      if (IN_W < 1 || IDX_W < 1) begin : g_bad
         $error("stgd_halve_stage: widths must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hold     <= '0;
         out_data <= '0;
         out_v    <= 1'b0;
         out_idx  <= '0;
      end else begin
         out_v <= in_v & in_idx[0];
         if (in_v) begin
            if (!in_idx[0]) begin
               hold <= in_data;
            end else begin
               out_data <= {in_data, hold};
               out_idx  <= in_idx >> 1;
            end
         end
      end
   end

   // R5: emitted groups never come back to back
   p_alt_r5: assert property (@(posedge clk) disable iff (rst)
      out_v |=> !out_v);

   // R5: every emitted group comes from an input group
   p_src_r5: assert property (@(posedge clk) disable iff (rst)
      out_v |-> $past(in_v));

endmodule

// File: rtl/stgd_deser.sv
module stgd_deser #(
   parameter int WORD_W = 8,
   parameter int DLY_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_in,
   input  logic [DLY_W-1:0]  dly_sel,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld,
   output logic              wr_ce
);
   import stgd_deser_pkg::*;

   localparam int NSTG    = $clog2(WORD_W);
   localparam int CE_PH   = emit_phase(WORD_W, NSTG);

   generate
      if (!is_pow2(WORD_W)) begin : g_bad_word
         $error("stgd_deser: WORD_W must be a power of two, at least 2");
      end
   endgenerate

   logic [NSTG-1:0] phase;
   logic            last;
   logic            dly_bit;

   stgd_phase_ctr #(
      .CNT_W (NSTG),
      .CE_PH (CE_PH)
   ) u_phase (
      .clk   (clk),
      .rst   (rst),
      .phase (phase),
      .last  (last),
      .wr_ce (wr_ce)
   );

   stgd_tap_delay #(
      .DLY_W (DLY_W)
   ) u_delay (
      .clk     (clk),
      .rst     (rst),
      .din     (ser_in),
      .dly_sel (dly_sel),
      .load    (last),
      .dout    (dly_bit)
   );

   genvar s;
   generate
      for (s = 0; s < NSTG; s++) begin : g_stg
         localparam int IN_W = 1 << s;
         logic [IN_W-1:0]   si;
         logic              vi;
         logic [NSTG-1:0]   ii;
         logic [2*IN_W-1:0] so;
         logic              vo;
         logic [NSTG-1:0]   io;

         if (s == 0) begin : g_src
            assign si = dly_bit;
            assign vi = 1'b1;
            assign ii = phase;
         end else begin : g_link
            assign si = g_stg[s-1].so;
            assign vi = g_stg[s-1].vo;
            assign ii = g_stg[s-1].io;
         end

         stgd_halve_stage #(
            .IN_W  (IN_W),
            .IDX_W (NSTG)
         ) u_half (
            .clk      (clk),
            .rst      (rst),
            .in_data  (si),
            .in_v     (vi),
            .in_idx   (ii),
            .out_data (so),
            .out_v    (vo),
            .out_idx  (io)
         );
      end
   endgenerate

   assign word_out = g_stg[NSTG-1].so;
   assign word_vld = g_stg[NSTG-1].vo;

   // R5: a word strobe only ever lines up with the write enable
   p_vld_ce_r5: assert property (@(posedge clk) disable iff (rst)
      word_vld |-> wr_ce);

   // R8: the word holds while no strobe is present
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !word_vld |-> $stable(word_out));

   // R4: the last stage only emits once all index bits are consumed
   p_idx_r4: assert property (@(posedge clk) disable iff (rst)
      word_vld |-> (g_stg[NSTG-1].io == '0));

endmodule

// File: tb/stgd_deser_bench.sv
module stgd_deser_bench;
   localparam int NCYC = 1536;

   logic       clk = 1'b0;
   logic       rst;
   logic       ser_in;
   logic [3:0] dly_sel;
   logic [7:0] word_out;
   logic       word_vld;
   logic       wr_ce;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   int din_h [0:NCYC-1];
   int ds_h  [0:NCYC-1];

   always #2 clk = ~clk;

   stgd_deser u_stgd_deser (
      .clk      (clk),
      .rst      (rst),
      .ser_in   (ser_in),
      .dly_sel  (dly_sel),
      .word_out (word_out),
      .word_vld (word_vld),
      .wr_ce    (wr_ce)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int eff_of_word(input int w);
      if (w == 0) return 0;
      return ds_h[8*w-1];
   endfunction

   function automatic int exp_bit(input int t);
      int e;
      int src;
      e   = eff_of_word(t / 8);
      src = t - e;
      if (src < 0) return 0;
      return din_h[src] & 1;
   endfunction

   initial begin
      logic [15:0] lfsr;
      int last_w;
      lfsr    = 16'hACE1;
      last_w  = 0;
      rst     = 1'b1;
      ser_in  = 1'b0;
      dly_sel = 4'd0;
      repeat (3) @(negedge clk);
      chk("R7 word after reset", word_out, 0);
      chk("R7 valid after reset", word_vld, 0);
      chk("R7 write enable after reset", wr_ce, 0);

      for (int t = 0; t < NCYC; t++) begin
         int seg;
         int mode;
         int dv;
         int b;
         int d;
         seg  = t / 32;
         mode = (seg / 16) % 3;
         dv   = seg % 16;
         if (mode == 1) begin
            b = (t % 9 == 0) ? 1 : 0;
         end else begin
            b    = lfsr[0];
            lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
         end
         if (mode == 2 && (t % 8) != 7) d = (dv ^ (t % 16)) & 15;
         else                           d = dv;
         din_h[t] = b;
         ds_h[t]  = d;
         rst      = 1'b0;
         ser_in   = b[0];
         dly_sel  = d[3:0];
         @(posedge clk);
         @(negedge clk);

         chk("R6 write enable", wr_ce, (t % 8 == 1) ? 1 : 0);
         if (t >= 9 && ((t - 9) % 8) == 0) begin
            int w;
            int ew;
            int e;
            int wm;
            chk("R5 word valid", word_vld, 1);
            w  = (t - 9) / 8;
            ew = 0;
            for (int i = 0; i < 8; i++) ew |= exp_bit(8*w + i) << i;
            e  = eff_of_word(w);
            wm = ((w * 8) / 32 / 16) % 3;
            if (wm == 2)     chk("R3 R4 word (noisy setting)", word_out, ew);
            else if (e == 0) chk("R1 R4 word (zero delay)", word_out, ew);
            else             chk("R2 R4 word (tap delay)", word_out, ew);
            last_w = ew;
         end else begin
            chk("R5 word valid low", word_vld, 0);
            chk("R8 word held", word_out, last_w);
         end
      end

      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R7 word after late reset", word_out, 0);
      chk("R7 valid after late reset", word_vld, 0);
      chk("R7 write enable after late reset", wr_ce, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule